// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

The block gathers fourteen interrupt source lines into a pending-request register. A second register holds a per-source enable mask and a master enable. Both registers are written through a set/clear protocol. The top data bit of a write chooses the direction: when it is 1, the written 1 bits are set; when it is 0, the written 1 bits are cleared. Bits written as 0 are left unchanged in either case.

A rising edge on a source line latches its request bit. The bit then stays pending until a write clears it. Software can also raise any request bit itself through a set write, which is how a coprocessor or a software interrupt is posted.

Each source belongs to a fixed priority level. A source counts as active when three bits are all 1: its request bit, its enable bit and the master enable. The block drives a registered 3-bit level to the CPU. That level is the highest level among the active sources, or 0 when no source is active. Levels run from 1 to 6.

Top module: `irq_level_ctrl`

## Requirements
- R1: A request-register write with data bit 15 = 1 sets every request bit whose data bit is 1 and leaves the others unchanged. The same holds for the enable register (bits 0..14).
- R2: A write with data bit 15 = 0 clears every bit whose data bit is 1 and leaves the others unchanged, in either register.
- R3: The request register stores bits 0..13 only, so a write to data bit 14 has no effect there. The request readback shows 0 in bits 15:14, and the enable readback shows 0 in bit 15.
- R4: When a source line goes from 0 to 1 between two clock edges, its request bit is 1 after the next edge. A line that stays high does not set its bit again after the bit has been cleared.
- R5: If a source edge and a clearing write hit the same request bit in the same cycle, the bit ends up set.
- R6: A request bit never returns to 0 except through a clearing write to the request register.
- R7: A source contributes to the level only when its request bit, its enable bit and enable-register bit 14 (the master enable) are all 1. With the master enable at 0, the level is 0.
- R8: The source-to-level map is: bits 0, 1 and 2 give level 1; bit 3 gives level 2; bits 4, 5 and 6 give level 3; bits 7 to 10 give level 4; bits 11 and 12 give level 5; bit 13 gives level 6.
- R9: The level output equals the highest level among the active sources, or 0 when none is active.
- R10: The level output never takes the value 7.
- R11: The level output changes on the clock edge that follows the register update which caused the change. Readbacks show a register update right after the edge that performs it.
- R12: After reset, both registers and the level output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 14 | Interrupt source lines; a rising edge latches the request bit |
| wr_req_i | input | 1 | Write strobe for the request register |
| wr_ena_i | input | 1 | Write strobe for the enable register |
| wr_data_i | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| req_rd_o | output | 16 | Pending-request readback |
| ena_rd_o | output | 16 | Enable-register readback, with the master enable in bit 14 |
| level_o | output | 3 | Registered priority level presented to the CPU |

## Verification
Register updates and source edges are visible on the readbacks right after the clock edge that samples them. The level output follows one edge later, because it is computed from the registers as they stood before that edge.

The bench drives inputs just after a falling edge and samples outputs at the following falling edge. At that point it compares the readbacks with the model state after the edge. It compares the level with a value computed from the model state as it stood one cycle earlier.

Directed sequences walk each source bit through the level map, toggle the master enable, and collide an edge with a clearing write. A seeded random phase then mixes source edges with writes in both directions to both registers.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC = 14;
    localparam int DATA_W  = 16;
    localparam int LVL_W   = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    // fixed mapping from source bit index to CPU priority level
    function automatic lvl_t lvl_of(input int idx);
        lvl_t l;
        if (idx <= 2)       l = lvl_t'(1);
        else if (idx == 3)  l = lvl_t'(2);
        else if (idx <= 6)  l = lvl_t'(3);
        else if (idx <= 10) l = lvl_t'(4);
        else if (idx <= 12) l = lvl_t'(5);
        else                l = lvl_t'(6);
        return l;
    endfunction
endpackage

// File: rtl/irq_src_edge.sv
module irq_src_edge #(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise_o[i] = src_i[i] & ~prev_q[i];
    end
endmodule

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic         set_dir_i,
    input  logic [W-1:0] wd_i,
    input  logic [W-1:0] hw_set_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (wr_i) begin
            if (set_dir_i) bits_d = bits_q | wd_i;
            else           bits_d = bits_q & ~wd_i;
        end
        // hardware set is applied last so it wins over a clearing write
        bits_d = bits_d | hw_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign q_o = bits_q;
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
    import irq_pkg::*;
#(
    parameter int N = 14
) (
    input  logic [N-1:0] act_i,
    output lvl_t         lvl_o
);
    always_comb begin
        lvl_o = '0;
        for (int i = 0; i < N; i++) begin
            if (act_i[i] && (lvl_of(i) > lvl_o)) lvl_o = lvl_of(i);
        end
    end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_pkg::*;
#(
    parameter int NSRC  = NUM_SRC,
    parameter int DW    = DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            wr_req_i,
    input  logic            wr_ena_i,
    input  logic [DW-1:0]   wr_data_i,
    output logic [DW-1:0]   req_rd_o,
    output logic [DW-1:0]   ena_rd_o,
    output logic [LVL_W-1:0] level_o
);
    localparam int DIR_BIT    = DW - 1;
    localparam int MASTER_BIT = NSRC;
    localparam int ENA_W      = NSRC + 1;

    typedef struct packed {
        lvl_t lvl;
    } state_t;

    state_t s_d, s_q;

    logic [NSRC-1:0]  rise;
    logic [NSRC-1:0]  req_q;
    logic [ENA_W-1:0] ena_q;
    logic [NSRC-1:0]  active;
    lvl_t             enc_lvl;

    irq_src_edge #(.N(NSRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .rise_o (rise)
    );

    irq_setclr_reg #(.W(NSRC)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_req_i),
        .set_dir_i (wr_data_i[DIR_BIT]),
        .wd_i      (wr_data_i[NSRC-1:0]),
        .hw_set_i  (rise),
        .q_o       (req_q)
    );

    irq_setclr_reg #(.W(ENA_W)) u_ena (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_ena_i),
        .set_dir_i (wr_data_i[DIR_BIT]),
        .wd_i      (wr_data_i[ENA_W-1:0]),
        .hw_set_i  ('0),
        .q_o       (ena_q)
    );

    assign active = req_q & ena_q[NSRC-1:0] & {NSRC{ena_q[MASTER_BIT]}};

    irq_level_enc #(.N(NSRC)) u_enc (
        .act_i (active),
        .lvl_o (enc_lvl)
    );

    always_comb begin
        s_d     = s_q;
        s_d.lvl = enc_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_rd_o = {{(DW-NSRC){1'b0}}, req_q};
    assign ena_rd_o = {{(DW-ENA_W){1'b0}}, ena_q};
    assign level_o  = s_q.lvl;
endmodule

module irq_level_ctrl_chk #(
    parameter int NSRC = 14,
    parameter int DW   = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_i,
    input logic            wr_req_i,
    input logic [DW-1:0]   req_rd_o,
    input logic [DW-1:0]   ena_rd_o,
    input logic [2:0]      level_o
);
    logic [NSRC-1:0] src_seen_q;
    logic [NSRC-1:0] edge_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_seen_q <= '0;
        else        src_seen_q <= src_i;
    end
    assign edge_now = src_i & ~src_seen_q;

    AST_LEVEL_NEVER_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
        level_o != 3'd7); // R10

    AST_MASTER_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_rd_o[NSRC] |=> level_o == 3'd0); // R7

    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req_i |=> ((req_rd_o & $past(req_rd_o)) == $past(req_rd_o))); // R6

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now != '0) |=> ((req_rd_o[NSRC-1:0] & $past(edge_now)) == $past(edge_now))); // R4

    AST_PAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd_o[DW-1:NSRC] == '0) && (ena_rd_o[DW-1] == 1'b0)); // R3
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .wr_req_i (wr_req_i),
    .req_rd_o (req_rd_o),
    .ena_rd_o (ena_rd_o),
    .level_o  (level_o)
);

// File: tb/irq_level_ctrl_tb.sv
`timescale 1ns/1ps
module irq_level_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] src = '0;
    logic        wr_req = 1'b0;
    logic        wr_ena = 1'b0;
    logic [15:0] wd = '0;
    logic [15:0] req_rd, ena_rd;
    logic [2:0]  level;

    int vectors = 0;
    int errors  = 0;

    logic [13:0] m_req = '0;
    logic [14:0] m_ena = '0;
    logic [13:0] m_prev = '0;
    logic [2:0]  m_lvl = '0;

    always #2 clk = ~clk;

    irq_level_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .wr_req_i  (wr_req),
        .wr_ena_i  (wr_ena),
        .wr_data_i (wd),
        .req_rd_o  (req_rd),
        .ena_rd_o  (ena_rd),
        .level_o   (level)
    );

    function automatic logic [2:0] map_lvl(input int b);
        case (b)
            0, 1, 2:      return 3'd1;
            3:            return 3'd2;
            4, 5, 6:      return 3'd3;
            7, 8, 9, 10:  return 3'd4;
            11, 12:       return 3'd5;
            default:      return 3'd6;
        endcase
    endfunction

    function automatic logic [2:0] ref_lvl(input logic [13:0] r, input logic [14:0] e);
        logic [2:0] best = 3'd0;
        if (!e[14]) return 3'd0;
        for (int b = 0; b < 14; b++)
            if (r[b] && e[b] && map_lvl(b) > best) best = map_lvl(b);
        return best;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: model the coming edge, then compare after it
    task automatic cyc(input string tag);
        logic [13:0] rise;
        m_lvl = ref_lvl(m_req, m_ena);
        rise = src & ~m_prev;
        m_prev = src;
        if (wr_req) m_req = wd[15] ? (m_req | wd[13:0]) : (m_req & ~wd[13:0]);
        if (wr_ena) m_ena = wd[15] ? (m_ena | wd[14:0]) : (m_ena & ~wd[14:0]);
        m_req = m_req | rise;
        @(posedge clk);
        @(negedge clk);
        check({tag, " req"}, req_rd, {2'b00, m_req});
        check({tag, " ena"}, ena_rd, {1'b0, m_ena});
        check({tag, " lvl"}, {13'd0, level}, {13'd0, m_lvl});
        wr_req = 1'b0;
        wr_ena = 1'b0;
        wd = '0;
    endtask

    task automatic wreq(input logic [15:0] d, input string tag);
        wr_req = 1'b1; wd = d; cyc(tag);
    endtask

    task automatic wena(input logic [15:0] d, input string tag);
        wr_ena = 1'b1; wd = d; cyc(tag);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check("R12 req reset", req_rd, 16'h0);
        check("R12 ena reset", ena_rd, 16'h0);
        check("R12 lvl reset", {13'd0, level}, 16'h0);
        rst_n = 1'b1;
        cyc("R12 idle");

        // R3: bit 14 of request not stored, pad bits zero
        wreq(16'hFFFF, "R3 req all");
        wreq(16'h7FFF, "R2 req clear all");
        wena(16'hFFFF, "R1 ena set all");
        cyc("R11 settle");

        // R8: walk each source bit alone through the map
        for (int b = 0; b < 14; b++) begin
            wreq(16'h8000 | (16'h1 << b), "R8 set");
            cyc("R11 lvl follows");
            cyc("R8 level map");
            wreq(16'h1 << b, "R2 clear");
            cyc("R9 none active");
        end

        // R9: highest wins
        wreq(16'h8000 | 16'h0084, "R9 mix");
        cyc("R9 settle");
        cyc("R9 highest");
        wreq(16'h8000 | 16'h2000, "R9 add top");
        cyc("R9 top wins");
        wreq(16'h3FFF, "R2 clear all");

        // R7: master enable and per-bit enable gate
        wreq(16'h8000 | 16'h0810, "R7 pend");
        wena(16'h4000, "R7 master off");
        cyc("R7 masked");
        cyc("R7 level zero");
        wena(16'h0800, "R7 bit off");
        wena(16'hC000, "R7 master on");
        cyc("R7 partial");
        cyc("R7 only enabled");
        wena(16'h8800, "R1 ena restore");
        wreq(16'h3FFF, "R2 clear all");

        // R4: rising edge sets; held high does not re-set
        src = 14'h0020;
        cyc("R4 edge");
        cyc("R6 sticky");
        wreq(16'h0020, "R4 clear while high");
        cyc("R4 no reset while high");
        src = 14'h0000;
        cyc("R6 src low stays clear");

        // R5: edge and clear in same cycle
        src = 14'h1000;
        wr_req = 1'b1; wd = 16'h1000;
        cyc("R5 collide");
        cyc("R5 held set");
        src = 14'h0000;
        wreq(16'h3FFF, "R2 clear all");

        // random phase
        for (int k = 0; k < 3000; k++) begin
            if (($urandom % 4) == 0) src = src ^ (14'h1 << ($urandom % 14));
            if (($urandom % 3) == 0) begin
                wr_req = 1'b1; wd = 16'($urandom) & 16'h80FF | (16'($urandom) & 16'h3F00);
            end else if (($urandom % 6) == 0) begin
                wr_ena = 1'b1; wd = 16'($urandom);
                if (($urandom % 4) != 0) wd[15] = 1'b1;
            end
            cyc("R1 R2 R6 R9 random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule